// File: doc/BRIEF.md
# Packed Single-Precision Max/Min Selector

This block chooses, lane by lane, either the larger or the smaller of two vectors of four single-precision values. One vector is the destination operand and the other is the source operand. It does no arithmetic. Every output lane is a bit-exact copy of one of the two input encodings for that lane. This lets it sit next to a vector register file as the select stage of a max/min operation.

NaN handling is deliberately one-sided. When either operand of a lane is NaN, the source encoding for that lane is returned unchanged, whichever operand held the NaN. Among ordered values, the destination lane wins only when it is strictly greater than the source (max) or strictly less than it (min). Ties therefore go to the source. A scalar mode confines the selection to the lowest lane and passes the three upper destination lanes through. The result is registered and appears one cycle after the input strobe.

Top module: `fp_maxmin_sel`

## Requirements
- R1: With op_min_i = 0 (max) and both lanes ordered, the output lane equals the dest lane when dest is strictly greater than src, and equals the src lane otherwise.
- R2: With op_min_i = 1 (min) and both lanes ordered, the output lane equals the dest lane when dest is strictly less than src, and equals the src lane otherwise.
- R3: A lane whose dest value is NaN (exponent bits 30:23 all ones, fraction bits 22:0 nonzero, any sign) yields the src lane encoding, in both max and min.
- R4: A lane whose src value is NaN yields the src lane encoding unchanged, in both max and min, including when both operands are NaN.
- R5: Numerically equal ordered operands, including +0 (0x00000000) against -0 (0x80000000), yield the src encoding.
- R6: Infinities take part in the ordering: +inf (0x7F800000) is above every finite value and -inf (0xFF800000) is below every finite value.
- R7: With scalar_i = 0, the four 32-bit lanes (bits 31:0, 63:32, 95:64, 127:96) are selected independently of each other.
- R8: With scalar_i = 1, only bits 31:0 are selected by the rules above, and bits 127:32 of the result equal bits 127:32 of dest.
- R9: valid_o is high in exactly the cycle after a cycle with valid_i high, and result_o is updated at the same time. When valid_i is low, result_o holds its value.
- R10: While rst_ni is low, valid_o is 0 and result_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid strobe |
| op_min_i | input | 1 | 0 selects max, 1 selects min |
| scalar_i | input | 1 | 1 restricts selection to lane 0 |
| dest_i | input | 128 | Destination operand, four FP32 lanes |
| src_i | input | 128 | Source operand, four FP32 lanes |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 128 | Selected lanes |

## Verification
The selection is exercised with distinct patterns in each lane:
- Mixed-sign finite values, including both negative. These separate a correct sign-magnitude ordering from a plain unsigned compare.
- Equal values and signed zeros. These show whether ties go to the source.
- Quiet, signalling and negative NaNs in dest only, in src only and in both. These separate the one-sided NaN rule from IEEE maxNum/minNum behaviour.
- Infinities against finite values.

Scalar vectors reuse packed operands that would change the upper lanes. Any leak of the selection past lane 0 therefore shows up. Idle cycles and back-to-back strobes check that results hold and that they pair with the right inputs.

// File: rtl/fpsel_pkg.sv
package fpsel_pkg;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = 23;
  localparam int unsigned LANE_W = 1 + EXP_W + MAN_W;
  localparam int unsigned LANES = 4;

  typedef enum logic {
    SEL_MAX = 1'b0,
    SEL_MIN = 1'b1
  } sel_op_e;
endpackage

// File: rtl/fpsel_nan_det.sv
module fpsel_nan_det #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val_i,
  output logic         nan_o
);
  logic exp_full;
  logic man_nz;

  assign exp_full = &val_i[W-2 -: EXP_W];
  assign man_nz   = |val_i[MAN_W-1:0];
  assign nan_o    = exp_full & man_nz;
endmodule

// File: rtl/fpsel_gt.sv
// Strict a > b for ordered (non-NaN) encodings; +0 and -0 compare equal.
module fpsel_gt #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  logic         sa, sb;
  logic [W-2:0] ma, mb;
  logic         both_zero;
  logic         mag_gt, mag_lt;

  assign sa        = a_i[W-1];
  assign sb        = b_i[W-1];
  assign ma        = a_i[W-2:0];
  assign mb        = b_i[W-2:0];
  assign both_zero = (ma == '0) && (mb == '0);
  assign mag_gt    = ma > mb;
  assign mag_lt    = ma < mb;

  always_comb begin
    unique case ({sa, sb})
      2'b01:   gt_o = !both_zero;
      2'b00:   gt_o = mag_gt;
      2'b11:   gt_o = mag_lt;
      default: gt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpsel_lane.sv
module fpsel_lane
  import fpsel_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  sel_op_e      op_i,
  input  logic [W-1:0] dest_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] res_o
);
  logic dest_nan, src_nan;
  logic dest_gt, dest_lt;
  logic take_dest;

  fpsel_nan_det #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nan_d (.val_i(dest_i), .nan_o(dest_nan));
  fpsel_nan_det #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nan_s (.val_i(src_i),  .nan_o(src_nan));

  fpsel_gt #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_gt (.a_i(dest_i), .b_i(src_i),  .gt_o(dest_gt));
  fpsel_gt #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lt (.a_i(src_i),  .b_i(dest_i), .gt_o(dest_lt));

  // any NaN forces src; ties fall through to src
  always_comb begin
    if (dest_nan || src_nan) take_dest = 1'b0;
    else if (op_i == SEL_MIN) take_dest = dest_lt;
    else take_dest = dest_gt;
  end

  assign res_o = take_dest ? dest_i : src_i;
endmodule

// File: rtl/fp_maxmin_sel.sv
module fp_maxmin_sel
  import fpsel_pkg::*;
#(
  parameter int unsigned EXP_W_P = fpsel_pkg::EXP_W,
  parameter int unsigned MAN_W_P = fpsel_pkg::MAN_W,
  parameter int unsigned LANES_P = fpsel_pkg::LANES,
  localparam int unsigned LW = 1 + EXP_W_P + MAN_W_P,
  localparam int unsigned VW = LW * LANES_P
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          op_min_i,
  input  logic          scalar_i,
  input  logic [VW-1:0] dest_i,
  input  logic [VW-1:0] src_i,
  output logic          valid_o,
  output logic [VW-1:0] result_o
);
  sel_op_e       op;
  logic [VW-1:0] sel_vec;

  assign op = op_min_i ? SEL_MIN : SEL_MAX;

  for (genvar l = 0; l < LANES_P; l++) begin : g_lane
    logic [LW-1:0] lane_res;

    fpsel_lane #(.EXP_W(EXP_W_P), .MAN_W(MAN_W_P)) u_lane (
      .op_i   (op),
      .dest_i (dest_i[l*LW +: LW]),
      .src_i  (src_i[l*LW +: LW]),
      .res_o  (lane_res)
    );

    if (l == 0) begin : g_low
      assign sel_vec[l*LW +: LW] = lane_res;
    end else begin : g_up
      assign sel_vec[l*LW +: LW] = scalar_i ? dest_i[l*LW +: LW] : lane_res;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= sel_vec;
    end
  end
endmodule

// File: rtl/fp_maxmin_sel_chk.sv
module fp_maxmin_sel_chk #(
  parameter int unsigned LW = 32,
  parameter int unsigned LANES = 4,
  parameter int unsigned EXP_W = 8,
  localparam int unsigned VW = LW * LANES
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          scalar_i,
  input logic [VW-1:0] dest_i,
  input logic [VW-1:0] src_i,
  input logic          valid_o,
  input logic [VW-1:0] result_o
);
  logic d0_nan, s0_nan;
  assign d0_nan = (&dest_i[LW-2 -: EXP_W]) && (|dest_i[LW-EXP_W-2:0]);
  assign s0_nan = (&src_i[LW-2 -: EXP_W]) && (|src_i[LW-EXP_W-2:0]);

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R9
  AST_SCALAR_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && scalar_i) |=> result_o[VW-1:LW] == $past(dest_i[VW-1:LW])); // R8
  AST_DEST_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && d0_nan) |=> result_o[LW-1:0] == $past(src_i[LW-1:0])); // R3
  AST_SRC_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && s0_nan) |=> result_o[LW-1:0] == $past(src_i[LW-1:0])); // R4

  for (genvar l = 0; l < LANES; l++) begin : g_pick
    AST_LANE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (result_o[l*LW +: LW] == $past(dest_i[l*LW +: LW])) ||
                  (result_o[l*LW +: LW] == $past(src_i[l*LW +: LW]))); // R7
  end
endmodule

bind fp_maxmin_sel fp_maxmin_sel_chk #(.LW(LW), .LANES(LANES_P), .EXP_W(EXP_W_P)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .scalar_i (scalar_i),
  .dest_i   (dest_i),
  .src_i    (src_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/fp_maxmin_sel_tb.sv
module fp_maxmin_sel_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         op_min_i = 1'b0;
  logic         scalar_i = 1'b0;
  logic [127:0] dest_i = '0;
  logic [127:0] src_i = '0;
  logic         valid_o;
  logic [127:0] result_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000, P3 = 32'h40400000;
  localparam logic [31:0] PH = 32'h3F000000, N1 = 32'hBF800000, N2 = 32'hC0000000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
  localparam logic [31:0] QNAN = 32'h7FC00000, SNAN = 32'h7F800001, NNAN = 32'hFFC00000;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fp_maxmin_sel u_dut (
    .clk_i, .rst_ni, .valid_i, .op_min_i, .scalar_i,
    .dest_i, .src_i, .valid_o, .result_o
  );

  function automatic bit is_nan(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  // monotonic unsigned key for ordered values, -0 folded onto +0
  function automatic logic [31:0] okey(logic [31:0] v);
    logic [31:0] t;
    t = (v[30:0] == 0) ? 32'h0 : v;
    return t[31] ? ~t : (t | 32'h80000000);
  endfunction

  function automatic logic [31:0] ref_lane(bit mn, logic [31:0] d, logic [31:0] s);
    if (is_nan(d) || is_nan(s)) return s;
    if (mn) return (okey(d) < okey(s)) ? d : s;
    return (okey(d) > okey(s)) ? d : s;
  endfunction

  function automatic logic [127:0] ref_vec(bit mn, bit sc, logic [127:0] d, logic [127:0] s);
    logic [127:0] r;
    for (int l = 0; l < 4; l++)
      r[l*32 +: 32] = (sc && l != 0) ? d[l*32 +: 32] : ref_lane(mn, d[l*32 +: 32], s[l*32 +: 32]);
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one strobe, sampled at the falling edge after the capturing edge
  task automatic run(string req, bit mn, bit sc, logic [127:0] d, logic [127:0] s);
    @(negedge clk_i);
    valid_i = 1'b1; op_min_i = mn; scalar_i = sc; dest_i = d; src_i = s;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " valid"}, {127'b0, valid_o}, 128'd1);
    chk(req, result_o, ref_vec(mn, sc, d, s));
  endtask

  task automatic t_reset();
    chk("R10 valid", {127'b0, valid_o}, 128'd0);
    chk("R10 result", result_o, 128'd0);
  endtask

  task automatic t_max_ordered();
    run("R1", 1'b0, 1'b0, {P2, N1, N2, PH}, {P1, P1, N1, P3});
    chk("R1 lanes", result_o, {P2, P1, N1, P3});
  endtask

  task automatic t_min_ordered();
    run("R2", 1'b1, 1'b0, {P2, N1, N2, PH}, {P1, P1, N1, P3});
    chk("R2 lanes", result_o, {P1, N1, N2, PH});
  endtask

  task automatic t_nan();
    run("R3", 1'b0, 1'b0, {QNAN, SNAN, NNAN, QNAN}, {P1, N2, PINF, PZ});
    chk("R3 max", result_o, {P1, N2, PINF, PZ});
    run("R3", 1'b1, 1'b0, {QNAN, SNAN, NNAN, QNAN}, {P1, N2, PINF, PZ});
    chk("R3 min", result_o, {P1, N2, PINF, PZ});
    run("R4", 1'b0, 1'b0, {P1, NINF, PINF, QNAN}, {QNAN, SNAN, NNAN, NNAN});
    chk("R4 max", result_o, {QNAN, SNAN, NNAN, NNAN});
    run("R4", 1'b1, 1'b0, {P1, NINF, PINF, SNAN}, {QNAN, SNAN, NNAN, QNAN});
    chk("R4 min", result_o, {QNAN, SNAN, NNAN, QNAN});
  endtask

  task automatic t_equal();
    run("R5", 1'b0, 1'b0, {PZ, NZ, P3, N1}, {NZ, PZ, P3, N1});
    chk("R5 max zeros", result_o, {NZ, PZ, P3, N1});
    run("R5", 1'b1, 1'b0, {PZ, NZ, P3, N1}, {NZ, PZ, P3, N1});
    chk("R5 min zeros", result_o, {NZ, PZ, P3, N1});
  endtask

  task automatic t_inf();
    run("R6", 1'b0, 1'b0, {PINF, NINF, P3, NINF}, {P3, N2, PINF, PINF});
    chk("R6 max", result_o, {PINF, N2, PINF, PINF});
    run("R6", 1'b1, 1'b0, {PINF, NINF, P3, NINF}, {P3, N2, PINF, PINF});
    chk("R6 min", result_o, {P3, NINF, P3, NINF});
  endtask

  task automatic t_packed_mix();
    run("R7", 1'b0, 1'b0, {N1, QNAN, P2, NZ}, {N2, P1, P2, PZ});
    chk("R7 independent", result_o, {N1, P1, P2, PZ});
  endtask

  task automatic t_scalar();
    run("R8", 1'b0, 1'b1, {P1, P2, P3, P2}, {P3, P3, P3, P1});
    chk("R8 max", result_o, {P1, P2, P3, P2});
    run("R8", 1'b1, 1'b1, {P1, P2, P3, QNAN}, {P3, P1, N1, N2});
    chk("R8 min nan", result_o, {P1, P2, P3, N2});
  endtask

  task automatic t_timing();
    logic [127:0] held;
    held = result_o;
    repeat (3) @(negedge clk_i);
    chk("R9 idle valid", {127'b0, valid_o}, 128'd0);
    chk("R9 hold", result_o, held);
    // back-to-back strobes
    @(negedge clk_i);
    valid_i = 1'b1; op_min_i = 1'b0; scalar_i = 1'b0;
    dest_i = {P1, P1, P1, P1}; src_i = {P2, P2, P2, P2};
    @(negedge clk_i);
    chk("R9 b2b first", result_o, {P2, P2, P2, P2});
    op_min_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R9 b2b second", result_o, {P1, P1, P1, P1});
    chk("R9 b2b valid", {127'b0, valid_o}, 128'd1);
    @(negedge clk_i);
    chk("R9 drop valid", {127'b0, valid_o}, 128'd0);
    chk("R9 hold after", result_o, {P1, P1, P1, P1});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R9 got=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_max_ordered();
    t_min_ordered();
    t_nan();
    t_equal();
    t_inf();
    t_packed_mix();
    t_scalar();
    t_timing();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule